// File: doc/BRIEF.md
# Sprite Memory Page Copier

This block moves one 256-byte page out of system RAM and into sprite attribute memory while the CPU is held in a stall. Software starts a copy by writing a page number. The block then raises a stall line to the CPU. It waits one or two alignment cycles, chosen from the parity of the CPU cycle in which the trigger arrived. After that it moves the page one byte at a time.

Each byte takes two cycles. In the first cycle the block puts out a RAM read strobe and address. In the second cycle it puts out a write strobe toward the data port of the sprite-memory register block, and the data is the byte that RAM returned. The register block's own pointer advances on every write. Because of this, the page lands starting at whatever pointer value was already set, and it wraps modulo 256. The RAM address is the page number times 256 plus the byte offset, reduced modulo the 2 KiB internal RAM size, since that RAM repeats across the address space.

Top module: `spr_dma`

## Requirements
- R1: While reset is high, and on the first cycle after reset, `stall`, `ram_rd`, `spr_wr` and `done` are all low.
- R2: A `trig_valid` pulse that is sampled while the block is idle makes `stall` go high in the very next cycle.
- R3: The number of alignment cycles is set by `cyc_odd`, sampled with the trigger. If `cyc_odd`=1, the first `ram_rd` comes 1 cycle after `stall` rises. If `cyc_odd`=0, it comes 2 cycles after. No strobe is active during the alignment cycles.
- R4: Each byte uses a `ram_rd` cycle followed at once by a `spr_wr` cycle. The two strobes are never high together. RAM answers one cycle after `ram_rd`, and `spr_wdata` in the write cycle equals that answer.
- R5: The n-th read (n = 0..255) presents `ram_addr` = (page*256 + n) mod 2048. Example: page 0x09 reads 0x100 through 0x1FF.
- R6: Each transfer makes exactly 256 `spr_wr` strobes.
- R7: `stall` stays high without a break for 513 cycles (`cyc_odd`=1) or 514 cycles (`cyc_odd`=0), and drops in the cycle after the last write.
- R8: `done` is high for exactly one cycle, the first cycle after the last write, when `stall` is already low.
- R9: A `trig_valid` that arrives while `stall` is high, including in the last write cycle, is ignored. The page, the byte count and the timing of the running transfer do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | Page-number write strobe that starts a copy |
| trig_page | input | 8 | Source page number |
| cyc_odd | input | 1 | High when the current CPU cycle count is odd |
| stall | output | 1 | Holds the CPU while a copy runs |
| ram_rd | output | 1 | RAM read strobe |
| ram_addr | output | 11 | RAM read address (mod 2 KiB) |
| ram_rdata | input | 8 | RAM read data, valid the cycle after `ram_rd` |
| spr_wr | output | 1 | Write strobe to the sprite-memory data port |
| spr_wdata | output | 8 | Byte written to the sprite-memory data port |
| done | output | 1 | One-cycle pulse when a copy finishes |

## Verification
The bench runs a copy for every page number, with the parity mixed across pages. A page above 7 that came out wrong would show that the 2 KiB mirroring was missed, because the bench compares against a modulo address. Every cycle is compared against a schedule worked out arithmetically. An alignment count that ignored parity, or was off by one, shows up as every strobe shifted by one cycle. A late stall release, or a `done` in the wrong place, breaks the 513/514-cycle window. Stray triggers are injected at the first alignment cycle, in the middle of the copy and in the final write cycle. A block that re-armed on any of them would restart its offsets, or switch to the stray page, or stretch the stall.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } dma_state_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic last;
    } beat_t;

    localparam int unsigned ALIGN_W = 2;

    // idle cycles inserted before the first read
    function automatic logic [ALIGN_W-1:0] align_len(input logic odd);
        return odd ? ALIGN_W'(1) : ALIGN_W'(2);
    endfunction

endpackage

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
    import spr_dma_pkg::*;
#(
    parameter int unsigned OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             cyc_odd,
    output logic             accept,
    output logic             busy,
    output beat_t            beat,
    output logic [OFF_W-1:0] off,
    output logic             done
);

    dma_state_t         state_q;
    logic [ALIGN_W-1:0] align_q;
    logic [OFF_W-1:0]   off_q;
    logic               done_q;

    always_comb begin
        accept    = (state_q == ST_IDLE) && trig;
        busy      = (state_q != ST_IDLE);
        beat.rd   = (state_q == ST_READ);
        beat.wr   = (state_q == ST_WRITE);
        beat.last = (state_q == ST_WRITE) && (off_q == {OFF_W{1'b1}});
        off       = off_q;
        done      = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            align_q <= '0;
            off_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (trig) begin
                        state_q <= ST_ALIGN;
                        align_q <= align_len(cyc_odd);
                        off_q   <= '0;
                    end
                end
                ST_ALIGN: begin
                    if (align_q == ALIGN_W'(1)) begin
                        state_q <= ST_READ;
                    end else begin
                        align_q <= align_q - ALIGN_W'(1);
                    end
                end
                ST_READ: begin
                    state_q <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (off_q == {OFF_W{1'b1}}) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        off_q   <= off_q + OFF_W'(1);
                        state_q <= ST_READ;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
        beat.rd |=> beat.wr);

    // R4
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        beat.wr |-> $past(beat.rd));

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(beat.last) && !busy));

endmodule

// File: rtl/spr_dma_addr.sv
module spr_dma_addr #(
    parameter int unsigned PAGE_W = 8,
    parameter int unsigned OFF_W  = 8,
    parameter int unsigned RAM_AW = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              busy,
    input  logic              trig,
    input  logic [PAGE_W-1:0] page_in,
    input  logic [OFF_W-1:0]  off,
    output logic [RAM_AW-1:0] ram_addr
);

    localparam int unsigned FULL_W = PAGE_W + OFF_W;

    logic [PAGE_W-1:0] page_q;
    logic [FULL_W-1:0] full_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else if (accept) begin
            page_q <= page_in;
        end
    end

    generate
        if (RAM_AW >= FULL_W) begin : g_wide
            always_comb ram_addr = RAM_AW'(full_addr);
        end else begin : g_mirror
            always_comb ram_addr = full_addr[RAM_AW-1:0];
        end
    endgenerate

    always_comb full_addr = {page_q, off};

    // R9
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && trig) |=> $stable(page_q));

endmodule

// File: rtl/spr_dma.sv
module spr_dma
    import spr_dma_pkg::*;
#(
    parameter int unsigned PAGE_W = 8,
    parameter int unsigned OFF_W  = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned RAM_AW = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_valid,
    input  logic [PAGE_W-1:0] trig_page,
    input  logic              cyc_odd,
    output logic              stall,
    output logic              ram_rd,
    output logic [RAM_AW-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              spr_wr,
    output logic [DATA_W-1:0] spr_wdata,
    output logic              done
);

    localparam int unsigned CNT_W = OFF_W + 1;
    localparam int unsigned BYTES = 1 << OFF_W;

    logic             accept;
    logic             busy;
    beat_t            beat;
    logic [OFF_W-1:0] off;
    logic             seq_done;

    spr_dma_seq #(.OFF_W(OFF_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig_valid),
        .cyc_odd (cyc_odd),
        .accept  (accept),
        .busy    (busy),
        .beat    (beat),
        .off     (off),
        .done    (seq_done)
    );

    spr_dma_addr #(
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W),
        .RAM_AW (RAM_AW)
    ) u_addr (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .busy     (busy),
        .trig     (trig_valid),
        .page_in  (trig_page),
        .off      (off),
        .ram_addr (ram_addr)
    );

    always_comb begin
        stall     = busy;
        ram_rd    = beat.rd;
        spr_wr    = beat.wr;
        spr_wdata = beat.wr ? ram_rdata : '0;
        done      = seq_done;
    end

    // write counter for the byte-count check
    logic [CNT_W-1:0] wr_cnt_q;
    always_ff @(posedge clk) begin
        if (rst || accept) begin
            wr_cnt_q <= '0;
        end else if (spr_wr) begin
            wr_cnt_q <= wr_cnt_q + CNT_W'(1);
        end
    end

    // R2
    stall_start_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_valid && !stall) |=> stall);

    // R3
    align_odd_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_valid && !stall && cyc_odd) |-> ##2 ram_rd);

    // R3
    align_even_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_valid && !stall && !cyc_odd) |-> ##2 (!ram_rd && stall) ##1 ram_rd);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ram_rd && spr_wr));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_rd && $past(ram_rd, 2)) |-> (ram_addr == $past(ram_addr, 2) + RAM_AW'(1)));

    // R6
    byte_count_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (wr_cnt_q == CNT_W'(BYTES)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/sim_spr_dma.sv
`timescale 1ns/1ps
module sim_spr_dma;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_valid = 1'b0;
    logic [7:0]  trig_page = 8'h00;
    logic        cyc_odd = 1'b0;
    logic        stall, ram_rd, spr_wr, done;
    logic [10:0] ram_addr;
    logic [7:0]  ram_rdata = 8'h00;
    logic [7:0]  spr_wdata;

    logic [7:0]  mem [2048];

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spr_dma u0 (
        .clk        (clk),
        .rst        (rst),
        .trig_valid (trig_valid),
        .trig_page  (trig_page),
        .cyc_odd    (cyc_odd),
        .stall      (stall),
        .ram_rd     (ram_rd),
        .ram_addr   (ram_addr),
        .ram_rdata  (ram_rdata),
        .spr_wr     (spr_wr),
        .spr_wdata  (spr_wdata),
        .done       (done)
    );

    // RAM model with one-cycle read latency
    always @(posedge clk) begin
        if (ram_rd) ram_rdata <= mem[ram_addr];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            if (n_bad <= 30) $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_xfer(input logic [7:0] pg, input bit odd, input int glitch_at);
        int align;
        int writes;
        align  = odd ? 1 : 2;
        writes = 0;
        @(negedge clk);
        trig_valid = 1'b1; trig_page = pg; cyc_odd = odd;
        @(negedge clk);
        trig_valid = 1'b0; trig_page = ~pg; cyc_odd = ~odd;
        for (int j = 0; j < align + 514; j++) begin
            int  k;
            bit  e_stall, e_done, e_rd, e_wr;
            int  e_addr;
            k       = j - align;
            e_stall = (j < align + 512);
            e_done  = (j == align + 512);
            e_rd    = (j >= align) && (k < 512) && (k % 2 == 0);
            e_wr    = (j >= align) && (k < 512) && (k % 2 == 1);
            e_addr  = ((int'(pg) << 8) + (k / 2)) & 32'h7FF;
            if (j == 0) check(stall == 1'b1, "R2 stall after trigger", int'(stall), 1);
            else        check(stall == e_stall, (glitch_at >= 0) ? "R7/R9 stall window" : "R7 stall window", int'(stall), int'(e_stall));
            check(done == e_done, "R8 done pulse", int'(done), int'(e_done));
            if (j < align) begin
                check(!ram_rd && !spr_wr, "R3 quiet alignment", int'({ram_rd, spr_wr}), 0);
            end else begin
                check(ram_rd == e_rd, "R3/R4 read strobe", int'(ram_rd), int'(e_rd));
                check(spr_wr == e_wr, "R4 write strobe", int'(spr_wr), int'(e_wr));
            end
            if (e_rd && ram_rd)
                check(int'(ram_addr) == e_addr, (glitch_at >= 0) ? "R5/R9 read address" : "R5 read address", int'(ram_addr), e_addr);
            if (e_wr && spr_wr)
                check(spr_wdata == mem[e_addr], "R4 write data", int'(spr_wdata), int'(mem[e_addr]));
            if (spr_wr) writes++;
            if (j == glitch_at) begin
                trig_valid = 1'b1; trig_page = pg ^ 8'h5A; cyc_odd = ~odd;
            end else begin
                trig_valid = 1'b0;
            end
            @(negedge clk);
        end
        trig_valid = 1'b0;
        check(writes == 256, "R6 byte count", writes, 256);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 37) ^ (i >> 8) ^ 8'hC3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!stall && !ram_rd && !spr_wr && !done, "R1 reset outputs",
              int'({stall, ram_rd, spr_wr, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!stall && !ram_rd && !spr_wr && !done, "R1 after reset",
              int'({stall, ram_rd, spr_wr, done}), 0);
        for (int p = 0; p < 256; p++) begin
            logic [7:0] pg;
            int g;
            pg = 8'(p);
            case (p % 4)
                0: g = (pg[0] ^ pg[3]) ? 512 : 513;
                1: g = 0;
                2: g = 137;
                default: g = -1;
            endcase
            run_xfer(pg, pg[0] ^ pg[3], g);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule